// File: doc/BRIEF.md
# Windowed Configuration Access Translator

This block lets a processor reach PCI configuration space through ordinary loads and stores into one fixed 4 MiB memory window, with no separate address and data register pair. Each access that lands in the window is turned into one configuration-space transaction: the target device is chosen by a one-hot select field in the address, the function and dword register come from other address fields, and the access size and byte offset become byte enables on a 32-bit little-endian lane bus.

A host that runs big-endian sets `swap_en`, and then 16-bit and 32-bit values are byte-reversed in both directions, while single bytes pass unchanged. Misaligned accesses are answered with an error and never reach the backend. Reads that the backend reports as unclaimed return all ones of the access width. Addresses outside the window are never claimed, so another decoder on the same request bus may take them.

Only one access is in flight at a time. The backend sees a valid/ready request, and a read is completed by a separate response strobe that carries the dword and a hit flag.

Top module: `cfg_window_bridge`

## Requirements
- R1: An access is claimed (`req_ready` high) only when `req_addr[31:22]` equals the window base `0x80800000` bits 31:22; for any other address `req_ready` stays low and no backend request is issued.
- R2: The device number is the index (0 to 10) of the lowest set bit among address bits 11 to 21, counted from bit 11; when none of those bits is set the device number is 11.
- R3: The backend address has bit 31 set, bits 30:16 zero, the device number in bits 15:11, address bits 10:8 (function) in bits 10:8, address bits 7:2 in bits 7:2 and bits 1:0 zero.
- R4: Size code 0 is one byte, 1 is two bytes, 2 is four bytes. Byte enables are `0001` shifted left by the offset `req_addr[1:0]` for one byte, `0011` shifted left by the offset for two bytes, and `1111` for four bytes.
- R5: Size code 3, a two-byte access at offset 3, or a four-byte access at a nonzero offset completes with `rsp_err` high, `rsp_rdata` zero, and no backend request.
- R6: Write data is taken right-aligned from `req_wdata` (low 8, 16 or 32 bits) and placed on `cfg_wdata` shifted up by eight times the offset; lanes outside the byte enables are zero.
- R7: Read data is taken from `cfg_rsp_data` shifted down by eight times the offset and returned right-aligned on `rsp_rdata`, with the bits above the access width zero.
- R8: With `swap_en` high at acceptance, two-byte and four-byte values have their byte order reversed on both write and read; one-byte values are unchanged.
- R9: A read whose backend response has `cfg_rsp_hit` low returns all ones of the access width (0xFF, 0xFFFF or 0xFFFFFFFF), zero above it.
- R10: While `cfg_valid` is high and `cfg_ready` low, `cfg_valid` and the backend address, enables and data hold; `req_ready` stays low from acceptance until the response, and each accepted access gives exactly one one-cycle `rsp_valid`.
- R11: After reset `cfg_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_en | input | 1 | Byte-reverse 2- and 4-byte data (big-endian host) |
| req_valid | input | 1 | Processor access request |
| req_ready | output | 1 | Access claimed and accepted this cycle |
| req_addr | input | 32 | Processor physical address |
| req_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:invalid) |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Completion was an alignment error |
| rsp_rdata | output | 32 | Load data, right-aligned |
| cfg_valid | output | 1 | Backend configuration request |
| cfg_ready | input | 1 | Backend takes the request |
| cfg_addr | output | 32 | Configuration address word |
| cfg_byten | output | 4 | Byte enables on the dword |
| cfg_write | output | 1 | Request is a write |
| cfg_wdata | output | 32 | Write data on little-endian lanes |
| cfg_rsp_valid | input | 1 | Backend read completion |
| cfg_rsp_hit | input | 1 | A device claimed the read |
| cfg_rsp_data | input | 32 | Read dword from the backend |

## Verification
The two functions that coincide on one read are the lane extraction with byte reversal and the all-ones fill for an unclaimed device: a two-byte read at offset 1 or 2 with `swap_en` high, answered with the hit flag low, must give 0x0000FFFF, while the same read with the hit flag high must give the swapped bytes taken from the shifted lanes. The random stream mixes offsets, sizes, swap settings and hit flags so these meet often, and the directed cases force them together; each completion is compared with a value the bench builds from the requirements. A second overlap, an alignment error decided in the same cycle a request is accepted, is provoked with illegal size and offset pairs and judged by the absence of any backend request before the error strobe.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int DWORD_W = 32;
  localparam int LANES   = DWORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [DWORD_W-1:0] cfg_addr;
    logic [LANES-1:0]   byten;
    logic [DWORD_W-1:0] wdata;
    logic               write;
    acc_size_e          size;
    logic [1:0]         off;
    logic               swap;
    logic               bad;
  } xfer_t;

  // illegal size/offset pairs
  function automatic logic is_misaligned(input acc_size_e sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return (off == 2'd3);
      SZ_WORD: return (off != 2'd0);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_enables(input acc_size_e sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: return 4'b0001 << off;
      SZ_HALF: return 4'b0011 << off;
      SZ_WORD: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  // all ones of the access width, right-aligned
  function automatic logic [DWORD_W-1:0] width_ones(input acc_size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // truncate to the access width, optionally reversing byte order
  function automatic logic [DWORD_W-1:0] order_fix(input logic [DWORD_W-1:0] d,
                                                   input acc_size_e sz, input logic swap);
    case (sz)
      SZ_BYTE: return {24'h0, d[7:0]};
      SZ_HALF: return swap ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
      default: return swap ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
  endfunction

  function automatic logic [DWORD_W-1:0] lane_shift_up(input logic [DWORD_W-1:0] d,
                                                       input logic [1:0] off);
    return d << {off, 3'b000};
  endfunction

  function automatic logic [DWORD_W-1:0] lane_shift_down(input logic [DWORD_W-1:0] d,
                                                         input logic [1:0] off);
    return d >> {off, 3'b000};
  endfunction

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter logic [31:0] WIN_BASE  = 32'h8080_0000,
  parameter int          WIN_LOG2  = 22,
  parameter int          IDSEL_LO  = 11,
  parameter int          IDSEL_CNT = 11
) (
  input  logic [31:0]      addr,
  input  acc_size_e        size,
  output logic             win_hit,
  output logic [31:0]      cfg_addr,
  output logic [LANES-1:0] byten,
  output logic             bad
);

  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int WIN_HI = 31;

  logic [DEV_W-1:0] dev_num;
  logic [FN_W-1:0]  fn_num;
  logic [5:0]       reg_dw;

  // lowest set select bit wins; none set gives IDSEL_CNT
  function automatic logic [DEV_W-1:0] pick_device(input logic [31:0] a);
    logic [DEV_W-1:0] d;
    logic             found;
    d     = DEV_W'(IDSEL_CNT);
    found = 1'b0;
    for (int i = 0; i < IDSEL_CNT; i++) begin
      if (!found && a[IDSEL_LO+i]) begin
        d     = DEV_W'(i);
        found = 1'b1;
      end
    end
    return d;
  endfunction

  function automatic logic [31:0] build_cfg(input logic [DEV_W-1:0] dv,
                                            input logic [FN_W-1:0] fn,
                                            input logic [5:0] rg);
    return {1'b1, 15'h0, dv, fn, rg, 2'b00};
  endfunction

  always_comb begin
    win_hit  = (addr[WIN_HI:WIN_LOG2] == WIN_BASE[WIN_HI:WIN_LOG2]);
    dev_num  = pick_device(addr);
    fn_num   = addr[10:8];
    reg_dw   = addr[7:2];
    cfg_addr = build_cfg(dev_num, fn_num, reg_dw);
    bad      = is_misaligned(size, addr[1:0]);
    byten    = bad ? '0 : lane_enables(size, addr[1:0]);
  end

endmodule

// File: rtl/cfgwin_lanes.sv
module cfgwin_lanes
  import cfgwin_pkg::*;
(
  input  acc_size_e          wr_size,
  input  logic [1:0]         wr_off,
  input  logic               wr_swap,
  input  logic [DWORD_W-1:0] wr_value,
  output logic [DWORD_W-1:0] wr_lanes,
  input  acc_size_e          rd_size,
  input  logic [1:0]         rd_off,
  input  logic               rd_swap,
  input  logic               rd_hit,
  input  logic [DWORD_W-1:0] rd_dword,
  output logic [DWORD_W-1:0] rd_value
);

  logic [DWORD_W-1:0] wr_ordered;
  logic [DWORD_W-1:0] rd_aligned;

  always_comb begin
    wr_ordered = order_fix(wr_value, wr_size, wr_swap);
    wr_lanes   = lane_shift_up(wr_ordered, wr_off);
  end

  always_comb begin
    rd_aligned = lane_shift_down(rd_dword, rd_off);
    rd_value   = rd_hit ? order_fix(rd_aligned, rd_size, rd_swap) : width_ones(rd_size);
  end

endmodule

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               win_hit,
  input  xfer_t              req_info,
  output logic               req_ready,
  output logic               cfg_valid,
  input  logic               cfg_ready,
  output logic [DWORD_W-1:0] cfg_addr,
  output logic [LANES-1:0]   cfg_byten,
  output logic               cfg_write,
  output logic [DWORD_W-1:0] cfg_wdata,
  input  logic               cfg_rsp_valid,
  input  logic [DWORD_W-1:0] rd_formatted,
  output acc_size_e          cur_size,
  output logic [1:0]         cur_off,
  output logic               cur_swap,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DWORD_W-1:0] rsp_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} st_e;

  st_e                state_q;
  xfer_t              held_q;
  logic               err_q;
  logic [DWORD_W-1:0] rdata_q;

  logic accept_ev;
  logic issue_fire_ev;
  logic read_done_ev;

  assign req_ready     = (state_q == ST_IDLE) && win_hit;
  assign accept_ev     = req_valid && req_ready;
  assign issue_fire_ev = (state_q == ST_ISSUE) && cfg_ready;
  assign read_done_ev  = (state_q == ST_WAIT) && cfg_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      held_q  <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_ev) begin
          held_q  <= req_info;
          err_q   <= req_info.bad;
          rdata_q <= '0;
          state_q <= req_info.bad ? ST_RESP : ST_ISSUE;
        end
        ST_ISSUE: if (issue_fire_ev) begin
          state_q <= held_q.write ? ST_RESP : ST_WAIT;
        end
        ST_WAIT: if (read_done_ev) begin
          rdata_q <= rd_formatted;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_valid = (state_q == ST_ISSUE);
  assign cfg_addr  = held_q.cfg_addr;
  assign cfg_byten = held_q.byten;
  assign cfg_write = held_q.write;
  assign cfg_wdata = held_q.wdata;
  assign cur_size  = held_q.size;
  assign cur_off   = held_q.off;
  assign cur_swap  = held_q.swap;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_rdata = rsp_valid ? rdata_q : '0;

  AST_BE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_byten) && $stable(cfg_wdata)); // R10

  AST_ERR_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && req_info.bad |=> !cfg_valid && rsp_valid && rsp_err); // R5

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10

  AST_CFG_WORD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> cfg_addr[31] && (cfg_addr[1:0] == 2'b00) && (cfg_addr[30:16] == 15'h0)); // R3

  AST_BYTEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_byten != '0)); // R4

endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfgwin_pkg::*;
#(
  parameter logic [31:0] WIN_BASE  = 32'h8080_0000,
  parameter int          WIN_LOG2  = 22,
  parameter int          IDSEL_LO  = 11,
  parameter int          IDSEL_CNT = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        swap_en,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        cfg_valid,
  input  logic        cfg_ready,
  output logic [31:0] cfg_addr,
  output logic [3:0]  cfg_byten,
  output logic        cfg_write,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_rsp_valid,
  input  logic        cfg_rsp_hit,
  input  logic [31:0] cfg_rsp_data
);

  acc_size_e          size_in;
  logic               win_hit;
  logic [31:0]        dec_cfg_addr;
  logic [LANES-1:0]   dec_byten;
  logic               dec_bad;
  logic [DWORD_W-1:0] placed_wdata;
  logic [DWORD_W-1:0] rd_formatted;
  acc_size_e          cur_size;
  logic [1:0]         cur_off;
  logic               cur_swap;
  xfer_t              req_info;

  assign size_in = acc_size_e'(req_size);

  cfgwin_decode #(
    .WIN_BASE (WIN_BASE),
    .WIN_LOG2 (WIN_LOG2),
    .IDSEL_LO (IDSEL_LO),
    .IDSEL_CNT(IDSEL_CNT)
  ) u_decode (
    .addr    (req_addr),
    .size    (size_in),
    .win_hit (win_hit),
    .cfg_addr(dec_cfg_addr),
    .byten   (dec_byten),
    .bad     (dec_bad)
  );

  cfgwin_lanes u_lanes (
    .wr_size (size_in),
    .wr_off  (req_addr[1:0]),
    .wr_swap (swap_en),
    .wr_value(req_wdata),
    .wr_lanes(placed_wdata),
    .rd_size (cur_size),
    .rd_off  (cur_off),
    .rd_swap (cur_swap),
    .rd_hit  (cfg_rsp_hit),
    .rd_dword(cfg_rsp_data),
    .rd_value(rd_formatted)
  );

  always_comb begin
    req_info          = '0;
    req_info.cfg_addr = dec_cfg_addr;
    req_info.byten    = dec_byten;
    req_info.wdata    = dec_bad ? '0 : placed_wdata;
    req_info.write    = req_write;
    req_info.size     = size_in;
    req_info.off      = req_addr[1:0];
    req_info.swap     = swap_en;
    req_info.bad      = dec_bad;
  end

  cfgwin_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .win_hit      (win_hit),
    .req_info     (req_info),
    .req_ready    (req_ready),
    .cfg_valid    (cfg_valid),
    .cfg_ready    (cfg_ready),
    .cfg_addr     (cfg_addr),
    .cfg_byten    (cfg_byten),
    .cfg_write    (cfg_write),
    .cfg_wdata    (cfg_wdata),
    .cfg_rsp_valid(cfg_rsp_valid),
    .rd_formatted (rd_formatted),
    .cur_size     (cur_size),
    .cur_off      (cur_off),
    .cur_swap     (cur_swap),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata)
  );

  AST_FWD_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(req_valid && req_ready && win_hit)); // R1

endmodule

// File: tb/cfg_window_bridge_test.sv
module cfg_window_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        cfg_valid;
  logic        cfg_ready = 1'b0;
  logic [31:0] cfg_addr;
  logic [3:0]  cfg_byten;
  logic        cfg_write;
  logic [31:0] cfg_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic        cfg_rsp_hit = 1'b0;
  logic [31:0] cfg_rsp_data = '0;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cfg_window_bridge uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int e_dev(input logic [31:0] a);
    int k = 0;
    while (k < 11 && !a[11+k]) k++;
    return k;
  endfunction

  function automatic logic [31:0] e_cfg(input logic [31:0] a);
    return 32'h8000_0000 | (32'(e_dev(a)) << 11) | ({29'h0, a[10:8]} << 8) | (a & 32'h0000_00FC);
  endfunction

  function automatic bit e_bad(input int sz, input int o);
    return (sz == 3) || (sz == 2 && o != 0) || (sz == 1 && o == 3);
  endfunction

  function automatic logic [3:0] e_be(input int sz, input int o);
    if (sz == 0) return 4'(1 << o);
    if (sz == 1) return 4'(3 << o);
    return 4'hF;
  endfunction

  function automatic logic [31:0] e_val(input logic [31:0] d, input int sz, input bit sw);
    if (sz == 0) return d & 32'hFF;
    if (sz == 1) return sw ? {16'h0, d[7:0], d[15:8]} : (d & 32'hFFFF);
    return sw ? {<<8{d}} : d;
  endfunction

  function automatic logic [31:0] e_rd(input logic [31:0] dw, input bit hit, input int sz, input int o, input bit sw);
    if (!hit) return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return e_val(dw >> (8 * o), sz, sw);
  endfunction

  // one complete access, acting as both processor and backend
  task automatic access(input logic [31:0] a, input int sz, input bit wr, input logic [31:0] wd,
                        input bit sw, input bit hit, input int stall, input int lat);
    int o = int'(a[1:0]);
    bit inwin = (a[31:22] == 10'h202);
    logic [31:0] dw;
    bit got;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 2'(sz); req_write = wr; req_wdata = wd; swap_en = sw;
    #1;
    if (!inwin) begin
      for (int i = 0; i < 5; i++) begin
        chk(!req_ready && !cfg_valid && !rsp_valid, "R1 out-of-window not claimed", {30'h0, req_ready, cfg_valid}, 32'h0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      return;
    end
    chk(req_ready === 1'b1, "R1 in-window claimed", {31'h0, req_ready}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 32'hDEAD_BEEF;
    chk(!req_ready, "R10 busy blocks new request", {31'h0, req_ready}, 32'h0);
    if (e_bad(sz, o)) begin
      chk(!cfg_valid && rsp_valid && rsp_err && rsp_rdata == 0, "R5 misaligned error, no forward",
          {rsp_rdata[28:0], cfg_valid, rsp_valid, rsp_err}, 32'h3);
      @(negedge clk);
      chk(!rsp_valid && !cfg_valid, "R10 single error strobe", {30'h0, rsp_valid, cfg_valid}, 32'h0);
      return;
    end
    chk(cfg_valid === 1'b1, "R10 backend request issued", {31'h0, cfg_valid}, 32'h1);
    chk(cfg_addr == e_cfg(a), "R2/R3 config address", cfg_addr, e_cfg(a));
    chk(cfg_byten == e_be(sz, o), "R4 byte enables", {28'h0, cfg_byten}, {28'h0, e_be(sz, o)});
    chk(cfg_write == wr, "R10 direction", {31'h0, cfg_write}, {31'h0, wr});
    if (wr) chk(cfg_wdata == (e_val(wd, sz, sw) << (8 * o)), "R6/R8 write lanes", cfg_wdata, e_val(wd, sz, sw) << (8 * o));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(cfg_valid && cfg_addr == e_cfg(a) && cfg_byten == e_be(sz, o), "R10 request held under stall",
          cfg_addr, e_cfg(a));
    end
    cfg_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_ready = 1'b0;
    if (wr) begin
      chk(rsp_valid && !rsp_err && !cfg_valid, "R10 write completion", {30'h0, rsp_valid, rsp_err}, 32'h2);
    end else begin
      chk(!rsp_valid && !cfg_valid, "R10 read waits for backend", {30'h0, rsp_valid, cfg_valid}, 32'h0);
      for (int i = 0; i < lat; i++) @(negedge clk);
      dw = e_cfg(a) * 32'h9E37_79B1 ^ 32'h1357_9BDF;
      cfg_rsp_valid = 1'b1; cfg_rsp_hit = hit; cfg_rsp_data = dw;
      @(posedge clk);
      @(negedge clk);
      cfg_rsp_valid = 1'b0; cfg_rsp_hit = 1'b0; cfg_rsp_data = '0;
      got = rsp_valid && !rsp_err;
      chk(got && rsp_rdata == e_rd(dw, hit, sz, o, sw), hit ? "R7/R8 read data" : "R9 absent device ones",
          rsp_rdata, e_rd(dw, hit, sz, o, sw));
    end
    @(negedge clk);
    chk(!rsp_valid, "R10 one response strobe", {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cfg_valid && !rsp_valid, "R11 reset state", {30'h0, cfg_valid, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cfg_valid && !rsp_valid, "R11 idle after reset", {30'h0, cfg_valid, rsp_valid}, 32'h0);

    // directed corners
    access(32'h8080_0000, 2, 0, 0, 0, 1, 0, 0);            // R2 no select bit: device 11
    access(32'h80A0_0300 | 32'h8, 2, 1, 32'hA1B2_C3D4, 0, 1, 2, 0); // R2 bit 21 only: device 10
    access(32'h8080_5804 | 32'h2, 1, 1, 32'h0000_1234, 1, 1, 0, 0); // lowest of several bits, swapped half at offset 2
    access(32'h8080_0801, 1, 0, 0, 1, 0, 0, 1);            // R9 with R8: absent, swapped half at offset 1
    access(32'h8080_0801, 1, 0, 0, 1, 1, 0, 1);            // R8 swapped half read at offset 1
    access(32'h8080_1003, 1, 0, 0, 0, 1, 0, 0);            // R5 half at offset 3
    access(32'h8080_1002, 2, 1, 32'h1, 0, 1, 0, 0);        // R5 word at offset 2
    access(32'h8080_1000, 3, 0, 0, 0, 1, 0, 0);            // R5 size code 3
    access(32'h8080_1003, 0, 1, 32'hFFFF_FF5A, 1, 1, 0, 0); // R8 byte unchanged with swap
    access(32'h8080_1003, 0, 0, 0, 1, 1, 0, 2);            // R7 byte read at offset 3
    access(32'h8080_2000, 2, 0, 0, 1, 0, 0, 0);            // R9 word ones
    access(32'h807F_FFFC, 2, 0, 0, 0, 1, 0, 0);            // R1 below window
    access(32'h80C0_0000, 2, 1, 32'h5, 0, 1, 0, 0);        // R1 above window

    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      a = 32'h8080_0000 | ($urandom & 32'h003F_FFFF);
      if (($urandom & 7) == 0) a = $urandom;
      access(a, int'($urandom % 4), bit'($urandom & 1), $urandom, bit'($urandom & 1),
             ($urandom % 4) != 0, int'($urandom % 3), int'($urandom % 3));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule